// File: doc/BRIEF.md
# Half-Rate Phase Enable Generator

This block serves a fast clock running at exactly twice the frequency of a related slow clock, where both clocks come from one source and their rising edges line up. In the fast domain it produces a clock enable that is high on every second fast cycle. The high cycle is the one that ends on a fast rising edge which coincides with a slow rising edge. Any fast-domain register gated by this enable therefore loads on the aligned edges, and a path launched from the slow domain gets a whole slow period for setup.

The enable's phase is tied to real slow-clock edges. It does not come from a free-running divider in the fast domain. In the default variant, a register on the slow clock inverts on every slow rising edge. The fast domain resamples that register, and an XOR of two consecutive samples marks every change in the sampled value, rising or falling. A parameter selects a second variant, which samples the slow clock itself on the falling fast edge and then on the rising fast edge. The block also carries a data word from the slow domain into the fast domain, loading it only on aligned edges.

The output data side follows stream conventions in one direction only. `fast_valid_o` is high for one fast cycle after each new word lands, and the block has no ready input. The slow source cannot be stalled, so a consumer that is not able to take a word when valid is high loses it. The word stays readable on `fast_data_o` until the next aligned capture.

Top module: `halfrate_phase_enable`

## Requirements
- R1: In toggle mode, the slow-domain phase register reads 0 after reset and inverts on every slow rising edge.
- R2: Once warmed up, `phase_ce_o` strictly alternates: it is high for one fast cycle and then low for one fast cycle.
- R3: `phase_ce_o` is high during the fast cycle in which the slow clock is low. That is the fast cycle whose closing rising edge coincides with a slow rising edge.
- R4: After each aligned edge, `fast_data_o` equals the value `slow_data_i` held throughout the preceding slow cycle.
- R5: `fast_data_o` does not change at any fast edge where `phase_ce_o` is low.
- R6: While `rst_i` is high, all of the following read 0 at every fast edge: `phase_ce_o`, `fast_valid_o` and `fast_data_o`. After release, `phase_ce_o` stays low until the fast domain has taken at least two samples.
- R7: `fast_valid_o` is high for exactly the one fast cycle that follows each capture and is low otherwise.
- R8: The direct-sampling variant (MODE = HR_DIRECT_SAMPLE) produces the same enable phase, data and valid timing as the toggle variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow clock, half the fast frequency, rising edges aligned with the fast clock |
| clk_fast_i | input | 1 | Fast clock |
| rst_i | input | 1 | Synchronous reset, active high, held for at least one slow period |
| slow_data_i | input | DATA_W | Word launched from slow-domain registers |
| phase_ce_o | output | 1 | Alignment enable in the fast domain |
| fast_data_o | output | DATA_W | Word captured on aligned fast edges |
| fast_valid_o | output | 1 | High for one fast cycle after each capture |

## Verification
A slow rising edge inverts the phase register. The enable goes high at the following mid-period fast edge and falls at the next aligned edge. That aligned edge also loads the word that was held during the slow cycle just ended, and it raises the valid flag for one fast cycle. The bench samples every output on fast falling edges. At the falling edge in the first half of a slow period it expects enable low, valid high and the fresh word. At the falling edge in the second half it expects enable high, valid low and the same word. Both variants run side by side on the same stimulus. The first slow period after each reset release is skipped before data checks begin.

// File: rtl/halfrate_pkg.sv
package halfrate_pkg;

  typedef enum logic {
    HR_TOGGLE_SYNC   = 1'b0,
    HR_DIRECT_SAMPLE = 1'b1
  } hr_mode_e;

  // Pick an even tap so that the XOR pair keeps the aligned phase
  function automatic int hr_tap(input int stages);
    int t;
    t = stages - 2;
    return t - (t % 2);
  endfunction

endpackage

// File: rtl/hr_slow_toggle.sv
module hr_slow_toggle (
  input  logic clk_slow_i,
  input  logic rst_i,
  output logic tgl_o
);

  always_ff @(posedge clk_slow_i) begin
    if (rst_i) tgl_o <= 1'b0;
    else       tgl_o <= ~tgl_o;
  end

  // R1: the phase register inverts on every slow edge
  p_toggle_flips_r1: assert property (@(posedge clk_slow_i) disable iff (rst_i)
    1'b1 |=> (tgl_o != $past(tgl_o)));

endmodule

// File: rtl/hr_toggle_detect.sv
module hr_toggle_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_fast_i,
  input  logic rst_i,
  input  logic tgl_i,
  output logic edge_o
);
  import halfrate_pkg::*;

  localparam int TAP = hr_tap(STAGES);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_fast_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], tgl_i};
  end

  assign edge_o = chain_q[TAP] ^ chain_q[TAP+1];

endmodule

// File: rtl/hr_direct_sample.sv
module hr_direct_sample (
  input  logic clk_fast_i,
  input  logic rst_i,
  input  logic clk_slow_i,
  output logic edge_o
);

  logic fall_q;

  always_ff @(negedge clk_fast_i) begin
    if (rst_i) fall_q <= 1'b0;
    else       fall_q <= clk_slow_i;
  end

  always_ff @(posedge clk_fast_i) begin
    if (rst_i) edge_o <= 1'b0;
    else       edge_o <= fall_q;
  end

endmodule

// File: rtl/hr_warmup.sv
module hr_warmup #(
  parameter int COUNT = 2
) (
  input  logic clk_fast_i,
  input  logic rst_i,
  output logic ready_o
);

  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(COUNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_fast_i) begin
    if (rst_i)              cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);

endmodule

// File: rtl/hr_word_capture.sv
module hr_word_capture #(
  parameter int W = 16
) (
  input  logic         clk_fast_i,
  input  logic         rst_i,
  input  logic         ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o,
  output logic         valid_o
);

  always_ff @(posedge clk_fast_i) begin
    if (rst_i) begin
      d_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ce_i;
      if (ce_i) d_o <= d_i;
    end
  end

  // R4: an enabled edge loads the slow word
  p_capture_r4: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    ce_i |=> (d_o == $past(d_i)));

  // R5: no change without the enable
  p_hold_r5: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    !ce_i |=> $stable(d_o));

  // R7: valid follows a capture by one cycle
  p_valid_after_r7: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    ce_i |=> valid_o);

endmodule

// File: rtl/halfrate_phase_enable.sv
module halfrate_phase_enable #(
  parameter int                     DATA_W      = 16,
  parameter int                     SYNC_STAGES = 2,
  parameter halfrate_pkg::hr_mode_e MODE        = halfrate_pkg::HR_TOGGLE_SYNC
) (
  input  logic              clk_slow_i,
  input  logic              clk_fast_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] slow_data_i,
  output logic              phase_ce_o,
  output logic [DATA_W-1:0] fast_data_o,
  output logic              fast_valid_o
);
  import halfrate_pkg::*;

  localparam int WARM = (MODE == HR_TOGGLE_SYNC) ? hr_tap(SYNC_STAGES) + 2 : 2;

  logic raw_edge;
  logic warm_ready;

  generate
    if (MODE == HR_TOGGLE_SYNC) begin : g_toggle
      logic tgl;
      hr_slow_toggle u_tgl (
        .clk_slow_i (clk_slow_i),
        .rst_i      (rst_i),
        .tgl_o      (tgl)
      );
      hr_toggle_detect #(.STAGES(SYNC_STAGES)) u_det (
        .clk_fast_i (clk_fast_i),
        .rst_i      (rst_i),
        .tgl_i      (tgl),
        .edge_o     (raw_edge)
      );
    end else begin : g_direct
      hr_direct_sample u_dir (
        .clk_fast_i (clk_fast_i),
        .rst_i      (rst_i),
        .clk_slow_i (clk_slow_i),
        .edge_o     (raw_edge)
      );
    end
  endgenerate

  hr_warmup #(.COUNT(WARM)) u_warm (
    .clk_fast_i (clk_fast_i),
    .rst_i      (rst_i),
    .ready_o    (warm_ready)
  );

  assign phase_ce_o = raw_edge & warm_ready;

  hr_word_capture #(.W(DATA_W)) u_cap (
    .clk_fast_i (clk_fast_i),
    .rst_i      (rst_i),
    .ce_i       (phase_ce_o),
    .d_i        (slow_data_i),
    .d_o        (fast_data_o),
    .valid_o    (fast_valid_o)
  );

  // R2: never two enabled cycles in a row
  p_ce_single_r2: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    phase_ce_o |=> !phase_ce_o);

  // R2: once warm, a low cycle is followed by a high one
  p_ce_refill_r2: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    (warm_ready && !phase_ce_o) |=> phase_ce_o);

  // R6: the enable is low on the first edge after reset
  p_reset_quiet_r6: assert property (@(posedge clk_fast_i)
    rst_i |=> !phase_ce_o);

endmodule

// File: tb/halfrate_phase_enable_bench.sv
module halfrate_phase_enable_bench;
  import halfrate_pkg::*;

  localparam int FAST_PERIOD = 10;
  localparam int DW = 16;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] din = '0;

  logic ce_a, ce_b, val_a, val_b;
  logic [DW-1:0] dout_a, dout_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(FAST_PERIOD/2) begin
    clk_fast = ~clk_fast;
    if (clk_fast) clk_slow = ~clk_slow;
  end

  halfrate_phase_enable #(.DATA_W(DW), .MODE(HR_TOGGLE_SYNC)) u_halfrate_phase_enable (
    .clk_slow_i(clk_slow), .clk_fast_i(clk_fast), .rst_i(rst),
    .slow_data_i(din), .phase_ce_o(ce_a), .fast_data_o(dout_a), .fast_valid_o(val_a));

  halfrate_phase_enable #(.DATA_W(DW), .MODE(HR_DIRECT_SAMPLE)) u_halfrate_phase_enable_direct (
    .clk_slow_i(clk_slow), .clk_fast_i(clk_fast), .rst_i(rst),
    .slow_data_i(din), .phase_ce_o(ce_b), .fast_data_o(dout_b), .fast_valid_o(val_b));

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R6: outputs stay at zero through reset, enable low just after release
  task automatic t_reset(input int slow_cycles);
    @(negedge clk_fast);
    rst = 1'b1;
    repeat (2 * slow_cycles) begin
      @(negedge clk_fast);
      check(ce_a == 0,     "R6 ce toggle",  DW'(ce_a), 0);
      check(ce_b == 0,     "R6 ce direct",  DW'(ce_b), 0);
      check(val_a == 0 && val_b == 0, "R6 valid", DW'({val_a, val_b}), 0);
      check(dout_a == 0 && dout_b == 0, "R6 data", dout_a | dout_b, 0);
    end
    while (clk_slow !== 1'b0) @(negedge clk_fast);
    rst = 1'b0;
    @(negedge clk_fast);
    check(ce_a == 0 && ce_b == 0, "R6 warmup low", DW'({ce_a, ce_b}), 0);
  endtask

  function automatic logic [DW-1:0] gen(input int kind, input int k);
    case (kind)
      0: return DW'(k * 3 + 1);
      1: return (k % 2) ? 16'hA55A : 16'h5AA5;
      2: return (k % 2) ? 16'hFFFF : 16'h0000;
      default: return DW'(16'h1357 ^ (k * 16'h0101));
    endcase
  endfunction

  // R1 R2 R3 R4 R5 R7 R8: per slow cycle, two falling-edge samples
  task automatic t_stream(input int kind, input int n);
    logic [DW-1:0] held;
    held = din;
    for (int k = 0; k < n; k++) begin
      @(posedge clk_slow);
      #1;
      din = gen(kind, k);
      @(negedge clk_fast);
      if (k > 0) begin
        check(ce_a == 0, "R3 ce low after aligned edge", DW'(ce_a), 0);
        check(dout_a == held, "R4 captured word", dout_a, held);
        check(val_a == 1, "R7 valid high", DW'(val_a), 1);
        check(ce_b == ce_a && dout_b == dout_a && val_b == val_a,
              "R8 direct matches", dout_b, dout_a);
      end
      @(negedge clk_fast);
      if (k > 0) begin
        check(ce_a == 1, "R2 R3 ce high before aligned edge", DW'(ce_a), 1);
        check(dout_a == held, "R5 word held", dout_a, held);
        check(val_a == 0, "R7 valid low", DW'(val_a), 0);
        check(ce_b == 1 && dout_b == held && val_b == 0,
              "R8 direct second half", dout_b, held);
      end
      held = din;
    end
  endtask

  initial begin
    t_reset(3);
    t_stream(0, 20);
    t_stream(1, 12);
    t_stream(2, 12);
    t_reset(2);
    t_stream(3, 16);
    summary();
  end

  initial begin
    #(FAST_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

endmodule